// File: doc/BRIEF.md
# Flash Write and Code-Fetch Collision Arbiter

This block shares one flash array between a processor that stores single bytes and a compute engine that runs periodic code passes out of flash. A software-controlled enable bit decides where each processor data-store cycle goes. When the bit is clear, the cycle goes to ordinary RAM. When the bit is set, the cycle becomes a flash byte program. A flash program holds the array for a fixed, parameterised number of cycles, and a busy flag is visible for that whole time.

The two users of the array cannot overlap. A processor program request that arrives while the engine is fetching, or in the same cycle an engine pass starts, is thrown away and raises the first collision interrupt. A pass-start pulse that arrives while a program is still running is skipped. The program then runs to completion and raises the second collision interrupt. Both interrupts hold until software writes 1 to clear them.

During a pass the block produces the engine fetch addresses. It starts from a 1 KB-aligned base chosen by an 8-bit location register and steps by one 16-bit word each cycle.

Top module: `flash_collision_arbiter`

## Requirements
- R1: While the enable bit `pwe_q` is 0, a data-store cycle (`st_req`=1) produces `ram_we`=1 with the same address and data one cycle later, and `fl_start` stays 0.
- R2: A `pwe_wr` strobe loads `pwe_wdata` into `pwe_q` only when `irq_glb_en` is 0. When `irq_glb_en` is 1 the strobe is ignored. A completed flash program never clears `pwe_q`.
- R3: While `pwe_q` is 1 and both the engine and the flash are idle, a data-store cycle pulses `fl_start` for one cycle, starting one cycle later, with the same address and data. `fl_busy` is then high for exactly WR_CYCLES consecutive cycles (4 by default).
- R4: A flash program request made while `eng_busy` is 1, or in the same cycle a pass starts, is not performed (`fl_start` stays 0), and `irq_col0` is 1 from the next cycle.
- R5: A `pass_tick` that arrives while `fl_busy` is 1 starts no pass (`eng_busy` and `fetch_valid` stay 0). The program keeps its full length, and `irq_col1` is 1 from the next cycle.
- R6: A `pass_tick` that arrives while both units are idle makes `fetch_valid` high for exactly PASS_WORDS consecutive cycles (6 by default), starting the next cycle. The k-th address (k from 0) is 1024*L + 2*k, where L is `loc_sel` sampled at the pass start.
- R7: `irq_col0` and `irq_col1` are sticky. Writing 1 to `irq_clr[0]` or `irq_clr[1]` clears the matching flag. A new collision in the same cycle wins over the clear.
- R8: A flash program request made while `fl_busy` is already 1 is dropped without raising any interrupt, and the running program keeps its address.
- R9: A `pass_tick` that arrives while a pass is running is ignored, so the pass still ends after PASS_WORDS cycles.
- R10: `fl_busy` and `eng_busy` are never 1 together.
- R11: After reset, `pwe_q`, `ram_we`, `fl_start`, `fl_busy`, `eng_busy`, `fetch_valid`, `irq_col0` and `irq_col1` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_req | input | 1 | Processor data-store cycle |
| st_addr | input | ADDR_W | Store byte address |
| st_data | input | 8 | Store byte data |
| pwe_wr | input | 1 | Write strobe for the program-enable bit |
| pwe_wdata | input | 1 | Value to write into the program-enable bit |
| irq_glb_en | input | 1 | Global interrupt enable; when 1, writes to the program-enable bit are ignored |
| pass_tick | input | 1 | Periodic request to start an engine pass |
| loc_sel | input | 8 | Engine code location, in 1 KB pages |
| irq_clr | input | 2 | Write-1-to-clear for the collision flags {col1, col0} |
| pwe_q | output | 1 | Current program-enable bit |
| ram_we | output | 1 | RAM byte write strobe |
| ram_addr | output | ADDR_W | RAM write address |
| ram_data | output | 8 | RAM write data |
| fl_start | output | 1 | One-cycle pulse that starts a flash byte program |
| fl_addr | output | ADDR_W | Flash program address |
| fl_data | output | 8 | Flash program data |
| fl_busy | output | 1 | A flash program is occupying the array |
| eng_busy | output | 1 | An engine pass is running |
| fetch_valid | output | 1 | An engine fetch address is valid |
| fetch_addr | output | ADDR_W | Engine fetch byte address |
| irq_col0 | output | 1 | Collision flag: program refused because of the engine |
| irq_col1 | output | 1 | Collision flag: pass skipped because of a program |

## Verification
Every result is registered, so it appears on the first clock edge after the stimulus. This covers the RAM strobe, `fl_start`, the start of `fl_busy`, the start of a pass and the collision flags. The bench drives inputs on a falling edge and samples half a cycle after the next rising edge. Each check therefore sees exactly one edge of effect. The two windows are counted one cycle at a time from that first sample. `fl_busy` must last WR_CYCLES samples. `fetch_valid` must last PASS_WORDS samples, and each fetch address is checked against its index. One more sample confirms that each window has closed.

// File: rtl/fca_pkg.sv
// Package: shared constants and address helpers for the flash collision arbiter.
// Assumes byte-addressed flash, 1 KB pages and 16-bit engine code words.
package fca_pkg;
    localparam int unsigned PAGE_LOG2 = 10;   // 1 KB erase page
    localparam int unsigned LOC_W     = 8;    // page-location register width
    localparam int unsigned BYTE_W    = 8;
    localparam int unsigned MAX_WORDS = 4096; // engine code size limit

    // Byte address of the first code word for a page location.
    function automatic logic [31:0] page_base(input logic [LOC_W-1:0] loc);
        return 32'(loc) << PAGE_LOG2;
    endfunction
endpackage

// File: rtl/fca_pwe_ctrl.sv
// Module: holds the program-enable bit and routes each processor store cycle.
// When the bit is clear, the store is registered onto the RAM port.
// When it is set, a flash request goes out combinationally.
// Assumes stores are single-cycle strobes.
module fca_pwe_ctrl
    import fca_pkg::*;
#(
    parameter int unsigned ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [BYTE_W-1:0] st_data,
    input  logic              pwe_wr,
    input  logic              pwe_wdata,
    input  logic              irq_glb_en,
    output logic              pwe_q,
    output logic              flash_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BYTE_W-1:0] ram_data
);
    // Enable bit: writable only while interrupts are globally disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            pwe_q <= 1'b0;
        else if (pwe_wr && !irq_glb_en)
            pwe_q <= pwe_wdata;
    end

    // RAM path: register the store when it is not steered to flash.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_we   <= 1'b0;
            ram_addr <= '0;
            ram_data <= '0;
        end else begin
            ram_we <= st_req && !pwe_q;
            if (st_req && !pwe_q) begin
                ram_addr <= st_addr;
                ram_data <= st_data;
            end
        end
    end

    // Flash path request.
    always_comb flash_req = st_req && pwe_q;

    // R2: a strobe while interrupts are enabled leaves the bit unchanged.
    p_pwe_locked_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwe_wr && irq_glb_en) |=> $stable(pwe_q));
    // R1: a RAM write strobe only follows a store cycle.
    p_ram_from_store_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> $past(st_req));
endmodule

// File: rtl/fca_flash_timer.sv
// Module: accepts flash byte programs and holds the array busy for WR_CYCLES cycles.
// A request is refused while the engine is busy or starting a pass (collision 0).
// A request is dropped silently while an earlier program is still running.
// Assumes eng_start is the same-cycle pass-start decision from the sequencer.
module fca_flash_timer
    import fca_pkg::*;
#(
    parameter int unsigned ADDR_W    = 18,
    parameter int unsigned WR_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flash_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [BYTE_W-1:0] req_data,
    input  logic              eng_busy,
    input  logic              eng_start,
    output logic              col0_set,
    output logic              fl_start,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [BYTE_W-1:0] fl_data,
    output logic              fl_busy
);
    localparam int unsigned CW = $clog2(WR_CYCLES + 1);

    logic [CW-1:0] remain;
    logic          accept;

    // Accept/refuse decision for this cycle.
    always_comb begin
        col0_set = flash_req && (eng_busy || eng_start);
        accept   = flash_req && !eng_busy && !eng_start && !fl_busy;
    end

    // Busy countdown and latched program address/data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remain   <= '0;
            fl_start <= 1'b0;
            fl_addr  <= '0;
            fl_data  <= '0;
        end else begin
            fl_start <= accept;
            if (accept) begin
                remain  <= CW'(WR_CYCLES);
                fl_addr <= req_addr;
                fl_data <= req_data;
            end else if (remain != '0) begin
                remain <= remain - 1'b1;
            end
        end
    end

    // Busy flag seen outside the block.
    always_comb fl_busy = (remain != '0);

    // R3: a program start pulse always comes with the busy flag.
    p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
        fl_start |-> fl_busy);
    // R8: a request made during a running program starts nothing new.
    p_drop_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && fl_busy) |=> (!fl_start && $stable(fl_addr)));
    // R4: a request made while the engine is busy starts nothing.
    p_refuse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (flash_req && eng_busy) |=> !fl_start);
endmodule

// File: rtl/fca_engine_seq.sv
// Module: runs engine code passes and generates the fetch address for each word.
// A pass starts on pass_tick only when the flash is idle.
// A tick during a program skips the pass (collision 1).
// Assumes PASS_WORDS does not exceed the 4096-word code limit.
module fca_engine_seq
    import fca_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned PASS_WORDS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pass_tick,
    input  logic              fl_busy,
    input  logic [LOC_W-1:0]  loc_sel,
    output logic              eng_start,
    output logic              col1_set,
    output logic              eng_busy,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr
);
    localparam int unsigned IDX_W = (PASS_WORDS > 1) ? $clog2(PASS_WORDS) : 1;
    localparam logic [IDX_W-1:0] LAST = IDX_W'(PASS_WORDS - 1);

    logic [IDX_W-1:0]  idx;
    logic [ADDR_W-1:0] base;

    // Start or skip decision.
    always_comb begin
        eng_start = pass_tick && !fl_busy && !eng_busy;
        col1_set  = pass_tick && fl_busy;
    end

    // Pass state: busy flag, word index and the base latched at the start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eng_busy <= 1'b0;
            idx      <= '0;
            base     <= '0;
        end else if (eng_start) begin
            eng_busy <= 1'b1;
            idx      <= '0;
            base     <= ADDR_W'(page_base(loc_sel));
        end else if (eng_busy) begin
            if (idx == LAST)
                eng_busy <= 1'b0;
            else
                idx <= idx + 1'b1;
        end
    end

    // Fetch address: base plus two bytes per word.
    always_comb begin
        fetch_valid = eng_busy;
        fetch_addr  = base + (ADDR_W'(idx) << 1);
    end

    initial begin
        assert (PASS_WORDS >= 1 && PASS_WORDS <= MAX_WORDS)
            else $error("PASS_WORDS out of range");
    end

    // R6: consecutive fetches step by one 16-bit word.
    p_fetch_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid)) |-> (fetch_addr == $past(fetch_addr) + ADDR_W'(2)));
    // R5: a tick during a program does not start a pass.
    p_skip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pass_tick && fl_busy && !eng_busy) |=> !eng_busy);
endmodule

// File: rtl/fca_irq.sv
// Module: two sticky collision flags with write-1-to-clear.
// A set in the same cycle as a clear wins.
module fca_irq (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       col0_set,
    input  logic       col1_set,
    input  logic [1:0] irq_clr,
    output logic       irq_col0,
    output logic       irq_col1
);
    // Flag update: set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_col0 <= 1'b0;
            irq_col1 <= 1'b0;
        end else begin
            irq_col0 <= col0_set || (irq_col0 && !irq_clr[0]);
            irq_col1 <= col1_set || (irq_col1 && !irq_clr[1]);
        end
    end

    // R7: a raised flag holds until it is cleared.
    p_sticky0_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_col0 && !irq_clr[0]) |=> irq_col0);
    p_sticky1_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_col1 && !irq_clr[1]) |=> irq_col1);
    // R4: collision 0 raises its flag.
    p_col0_r4: assert property (@(posedge clk) disable iff (!rst_n)
        col0_set |=> irq_col0);
    // R5: collision 1 raises its flag.
    p_col1_r5: assert property (@(posedge clk) disable iff (!rst_n)
        col1_set |=> irq_col1);
endmodule

// File: rtl/flash_collision_arbiter.sv
// Module: top level of the flash program / engine fetch collision arbiter.
// Connects enable-bit steering, the program timer, the pass sequencer and
// the collision flags.
// Assumes a single clock and synchronous active-low reset.
module flash_collision_arbiter
    import fca_pkg::*;
#(
    parameter int unsigned ADDR_W     = 18,
    parameter int unsigned WR_CYCLES  = 4,
    parameter int unsigned PASS_WORDS = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              st_req,
    input  logic [ADDR_W-1:0] st_addr,
    input  logic [7:0]        st_data,
    input  logic              pwe_wr,
    input  logic              pwe_wdata,
    input  logic              irq_glb_en,
    input  logic              pass_tick,
    input  logic [7:0]        loc_sel,
    input  logic [1:0]        irq_clr,
    output logic              pwe_q,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [7:0]        ram_data,
    output logic              fl_start,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_data,
    output logic              fl_busy,
    output logic              eng_busy,
    output logic              fetch_valid,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              irq_col0,
    output logic              irq_col1
);
    logic flash_req, eng_start, col0_set, col1_set;

    fca_pwe_ctrl #(.ADDR_W(ADDR_W)) u_pwe (
        .clk(clk), .rst_n(rst_n), .st_req(st_req), .st_addr(st_addr),
        .st_data(st_data), .pwe_wr(pwe_wr), .pwe_wdata(pwe_wdata),
        .irq_glb_en(irq_glb_en), .pwe_q(pwe_q), .flash_req(flash_req),
        .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data)
    );

    fca_flash_timer #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .flash_req(flash_req), .req_addr(st_addr),
        .req_data(st_data), .eng_busy(eng_busy), .eng_start(eng_start),
        .col0_set(col0_set), .fl_start(fl_start), .fl_addr(fl_addr),
        .fl_data(fl_data), .fl_busy(fl_busy)
    );

    fca_engine_seq #(.ADDR_W(ADDR_W), .PASS_WORDS(PASS_WORDS)) u_eng (
        .clk(clk), .rst_n(rst_n), .pass_tick(pass_tick), .fl_busy(fl_busy),
        .loc_sel(loc_sel), .eng_start(eng_start), .col1_set(col1_set),
        .eng_busy(eng_busy), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr)
    );

    fca_irq u_irq (
        .clk(clk), .rst_n(rst_n), .col0_set(col0_set), .col1_set(col1_set),
        .irq_clr(irq_clr), .irq_col0(irq_col0), .irq_col1(irq_col1)
    );

    // R10: the array never serves a program and a pass at the same time.
    p_exclusive_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(fl_busy && eng_busy));
    // R1: a store with the enable bit clear never starts a program.
    p_no_flash_when_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (st_req && !pwe_q) |=> !fl_start);
endmodule

// File: tb/tb_flash_collision_arbiter.sv
module tb_flash_collision_arbiter;
    localparam int ADDR_W = 18;
    localparam int WR_CYC = 4;
    localparam int PASS_W = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_req = 0, pwe_wr = 0, pwe_wdata = 0, irq_glb_en = 0, pass_tick = 0;
    logic [ADDR_W-1:0] st_addr = '0;
    logic [7:0] st_data = '0, loc_sel = '0;
    logic [1:0] irq_clr = '0;
    logic pwe_q, ram_we, fl_start, fl_busy, eng_busy, fetch_valid, irq_col0, irq_col1;
    logic [ADDR_W-1:0] ram_addr, fl_addr, fetch_addr;
    logic [7:0] ram_data, fl_data;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    flash_collision_arbiter #(.ADDR_W(ADDR_W), .WR_CYCLES(WR_CYC), .PASS_WORDS(PASS_W)) dut (
        .clk(clk), .rst_n(rst_n), .st_req(st_req), .st_addr(st_addr), .st_data(st_data),
        .pwe_wr(pwe_wr), .pwe_wdata(pwe_wdata), .irq_glb_en(irq_glb_en),
        .pass_tick(pass_tick), .loc_sel(loc_sel), .irq_clr(irq_clr),
        .pwe_q(pwe_q), .ram_we(ram_we), .ram_addr(ram_addr), .ram_data(ram_data),
        .fl_start(fl_start), .fl_addr(fl_addr), .fl_data(fl_data), .fl_busy(fl_busy),
        .eng_busy(eng_busy), .fetch_valid(fetch_valid), .fetch_addr(fetch_addr),
        .irq_col0(irq_col0), .irq_col1(irq_col1)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s got=0x%0h exp=0x%0h", req, got, exp);
        end
    endtask

    // One rising edge, then sample at the following falling edge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pwe(input logic v, input logic glb);
        pwe_wr = 1; pwe_wdata = v; irq_glb_en = glb;
        step();
        pwe_wr = 0; irq_glb_en = 0;
    endtask

    task automatic clear_irqs();
        irq_clr = 2'b11;
        step();
        irq_clr = 2'b00;
    endtask

    task automatic t_reset();
        check("R11 pwe_q", pwe_q, 0);
        check("R11 ram_we", ram_we, 0);
        check("R11 fl_start", fl_start, 0);
        check("R11 fl_busy", fl_busy, 0);
        check("R11 eng_busy", eng_busy, 0);
        check("R11 fetch_valid", fetch_valid, 0);
        check("R11 irq_col0", irq_col0, 0);
        check("R11 irq_col1", irq_col1, 0);
    endtask

    task automatic t_ram_path();
        st_req = 1; st_addr = 18'h01234; st_data = 8'h5A;
        step();
        st_req = 0;
        check("R1 ram_we", ram_we, 1);
        check("R1 ram_addr", ram_addr, 18'h01234);
        check("R1 ram_data", ram_data, 8'h5A);
        check("R1 no fl_start", fl_start, 0);
        step();
        check("R1 ram_we single", ram_we, 0);
    endtask

    task automatic t_pwe_lock();
        set_pwe(1'b1, 1'b1);
        check("R2 write ignored with irq enabled", pwe_q, 0);
        set_pwe(1'b1, 1'b0);
        check("R2 write taken with irq disabled", pwe_q, 1);
        set_pwe(1'b0, 1'b1);
        check("R2 clear ignored with irq enabled", pwe_q, 1);
    endtask

    task automatic t_flash_write();
        int n;
        st_req = 1; st_addr = 18'h2ABCD; st_data = 8'hC3;
        step();
        st_req = 0;
        check("R3 fl_start", fl_start, 1);
        check("R3 fl_addr", fl_addr, 18'h2ABCD);
        check("R3 fl_data", fl_data, 8'hC3);
        check("R1 no ram_we in flash mode", ram_we, 0);
        n = 0;
        while (fl_busy && n < 20) begin
            n++;
            step();
            if (n == 1) check("R3 start is one pulse", fl_start, 0);
        end
        check("R3 busy length", n, WR_CYC);
        check("R2 pwe_q kept after program", pwe_q, 1);
    endtask

    task automatic t_drop_busy();
        st_req = 1; st_addr = 18'h00100; st_data = 8'h11;
        step();
        st_addr = 18'h00200; st_data = 8'h22;
        step();
        st_req = 0;
        check("R8 second start absent", fl_start, 0);
        check("R8 address kept", fl_addr, 18'h00100);
        check("R8 no col0", irq_col0, 0);
        check("R8 no col1", irq_col1, 0);
        for (int i = 0; i < WR_CYC; i++) step();
        check("R3 idle again", fl_busy, 0);
    endtask

    task automatic t_pass(input logic [7:0] loc);
        loc_sel = loc; pass_tick = 1;
        step();
        pass_tick = 0; loc_sel = 8'hFF;
        for (int k = 0; k < PASS_W; k++) begin
            check("R6 fetch_valid", fetch_valid, 1);
            check("R6 fetch_addr", fetch_addr, (32'(loc) << 10) + 32'(2 * k));
            if (k == 1) pass_tick = 1;
            step();
            pass_tick = 0;
        end
        check("R6 R9 pass ends", fetch_valid, 0);
        check("R9 no restart", eng_busy, 0);
    endtask

    task automatic t_col0();
        pass_tick = 1; loc_sel = 8'd2;
        step();
        pass_tick = 0;
        st_req = 1; st_addr = 18'h00333;
        step();
        st_req = 0;
        check("R4 refused", fl_start, 0);
        check("R4 col0 set", irq_col0, 1);
        check("R10 flash idle", fl_busy, 0);
        irq_clr = 2'b01;
        step();
        irq_clr = 2'b00;
        check("R7 col0 cleared", irq_col0, 0);
        for (int i = 0; i < PASS_W; i++) step();
        check("R6 engine idle", eng_busy, 0);
        pass_tick = 1; st_req = 1;
        step();
        pass_tick = 0; st_req = 0;
        check("R4 same-cycle refused", fl_start, 0);
        check("R4 same-cycle col0", irq_col0, 1);
        check("R4 pass started", eng_busy, 1);
        for (int i = 0; i < PASS_W; i++) step();
        clear_irqs();
    endtask

    task automatic t_col1();
        st_req = 1; st_addr = 18'h00444;
        step();
        st_req = 0;
        pass_tick = 1;
        step();
        pass_tick = 0;
        check("R5 col1 set", irq_col1, 1);
        check("R5 pass skipped", fetch_valid, 0);
        check("R5 program continues", fl_busy, 1);
        step(); step();
        check("R5 busy at last cycle", fl_busy, 1);
        step();
        check("R5 program ends on time", fl_busy, 0);
        check("R5 still no pass", eng_busy, 0);
        irq_clr = 2'b10; st_req = 1;
        step();
        st_req = 0; irq_clr = 2'b00;
        pass_tick = 1;
        step();
        pass_tick = 0;
        check("R7 set wins over earlier clear", irq_col1, 1);
        irq_clr = 2'b10; pass_tick = 1;
        step();
        irq_clr = 2'b00; pass_tick = 0;
        check("R7 set wins in same cycle", irq_col1, 1);
        check("R7 col0 untouched", irq_col0, 0);
        for (int i = 0; i < WR_CYC; i++) step();
        clear_irqs();
        check("R7 both cleared", {irq_col1, irq_col0}, 2'b00);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        t_reset();
        t_ram_path();
        t_pwe_lock();
        t_flash_write();
        t_drop_busy();
        set_pwe(1'b0, 1'b0);
        check("R2 software clear", pwe_q, 0);
        t_pass(8'd3);
        t_pass(8'd255);
        set_pwe(1'b1, 1'b0);
        t_col0();
        t_col1();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule